// File: doc/BRIEF.md
# Buffered SPI Master Transmitter

This block is the transmit side of an SPI master. Software hands it 8-bit bytes through a simple write strobe. An accepted byte waits in a one-byte holding register until the shift register is free. The shift register then drives the byte onto MOSI, most significant bit first, while the block generates SCK. A flag tells the writer when the holding register can take another byte. A byte written while a transfer is running is therefore sent straight after it, with no idle clock between the two.

SCK is derived from a divider counter that runs freely from reset and is never restarted by a write. A transfer can begin only on a period boundary of that counter, so the delay from a write to the start of shifting varies. There are as many possible start points as the selected divide ratio. Idle clock polarity and clock phase are both selectable.

Top module: `spi_tx_master`

## Requirements
- R1: After reset, tx_empty is 1 and busy is 0, and within two clocks of reset release sck sits at the cpol level.
- R2: div_sel selects the SCK period in system clocks: code 0 gives 2, code 1 gives 8, code 2 gives 32 and code 3 gives 128. A single byte keeps busy high for exactly 8 SCK periods.
- R3: Each byte goes out MSB first as 8 bits, and the receiver sees exactly the bytes that were accepted, in order.
- R4: While idle, sck rests at the cpol level. It returns there when the last byte finishes and follows cpol one clock after cpol changes.
- R5: MOSI changes only at the start of an SCK period. With cpha=0 the bit is sampled on the edge leaving the idle level, in mid-period. With cpha=1, MOSI changes on the edge leaving the idle level and the bit is sampled on the edge returning to it.
- R6: tx_empty drops in the clock after an accepted write. It rises again in the same clock that busy shows the held byte moving into the shift register.
- R7: A write while tx_empty is 0 is ignored. It changes neither the held byte nor the byte being shifted.
- R8: Shifting starts only at a period boundary of the free-running divider. Counting from the clock edge that accepts the write into an idle block, busy rises between 1 and N clocks later, where N is the divide ratio.
- R9: A byte held while another is shifting starts at once when that byte ends. For two such bytes busy stays high for exactly 16 SCK periods.
- R10: busy falls in the clock the last bit period of the final queued byte ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_sel | input | 2 | SCK divide select: 0 gives /2, 1 gives /8, 2 gives /32, 3 gives /128 |
| cpol | input | 1 | Idle level of sck |
| cpha | input | 1 | Clock phase: 0 samples on the leading edge, 1 on the trailing edge |
| wr_en | input | 1 | Write strobe for wr_data |
| wr_data | input | 8 | Byte to send |
| tx_empty | output | 1 | Holding register can accept a byte |
| busy | output | 1 | A byte is being shifted out |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |

## Verification
The assertions assume that div_sel and cpha stay constant while busy is high. They also assume that cpol changes only while the block is idle, so the idle-level check lets sck settle for one clock after a change. The bench changes mode and divider only after it has seen busy low and tx_empty high. It writes a second byte only after tx_empty has come back, except in the one step that tests an ignored write. The bench also moves the write time against the divider phase, so that the start delay lands on different points within the window.

// File: rtl/spi_tx_master.sv
module spi_tx_master #(
  parameter int DW    = 8,
  parameter int CNT_W = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    div_sel,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          tx_empty,
  output logic          busy,
  output logic          sck,
  output logic          mosi
);
  localparam int BIT_W = $clog2(DW);
  localparam logic [BIT_W-1:0] LAST = BIT_W'(DW - 1);

  logic [CNT_W-1:0] cnt, mask;
  logic [DW-1:0]    hold, shreg;
  logic [BIT_W-1:0] bitcnt;
  logic             hold_full, active, sck_r;
  logic             tick, half, load, last_bit;

  always_comb begin
    case (div_sel)
      2'd0:    mask = CNT_W'(1);
      2'd1:    mask = CNT_W'(7);
      2'd2:    mask = CNT_W'(31);
      default: mask = CNT_W'(127);
    endcase
  end

  assign tick     = (cnt & mask) == mask;
  assign half     = (cnt & mask) == (mask >> 1);
  assign last_bit = bitcnt == LAST;
  assign load     = tick && hold_full && (!active || last_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      hold      <= '0;
      hold_full <= 1'b0;
      shreg     <= '0;
      bitcnt    <= '0;
      active    <= 1'b0;
      sck_r     <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;

      if (load) begin
        shreg     <= hold;
        bitcnt    <= '0;
        active    <= 1'b1;
        hold_full <= 1'b0;
      end else begin
        if (wr_en && !hold_full) begin
          hold      <= wr_data;
          hold_full <= 1'b1;
        end
        if (tick && active) begin
          if (last_bit) begin
            active <= 1'b0;
          end else begin
            bitcnt <= bitcnt + 1'b1;
            shreg  <= {shreg[DW-2:0], 1'b0};
          end
        end
      end

      if (!active && !load)
        sck_r <= cpol;
      else if (tick)
        sck_r <= (load || !last_bit) ? (cpha ? ~cpol : cpol) : cpol;
      else if (half)
        sck_r <= cpha ? cpol : ~cpol;
    end
  end

  assign tx_empty = ~hold_full;
  assign busy     = active;
  assign sck      = sck_r;
  assign mosi     = shreg[DW-1];
endmodule

module spi_tx_master_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpol,
  input logic          wr_en,
  input logic          tx_empty,
  input logic          busy,
  input logic          sck,
  input logic          mosi,
  input logic          tick,
  input logic [DW-1:0] hold
);
  p_empty_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && tx_empty |=> !tx_empty);

  p_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !tx_empty |=> $stable(hold));

  p_start_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tick));

  p_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !busy && $past(!busy) && $stable(cpol) |-> sck == cpol);

  p_mosi_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !$stable(mosi) |-> $past(tick));

  p_seamless_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tx_empty));
endmodule

bind spi_tx_master spi_tx_master_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpol(cpol), .wr_en(wr_en), .tx_empty(tx_empty),
  .busy(busy), .sck(sck), .mosi(mosi), .tick(tick), .hold(hold)
);

// File: tb/tb_spi_tx_master.sv
`timescale 1ns/1ps
module tb_spi_tx_master;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] div_sel;
  logic       cpol, cpha, wr_en;
  logic [7:0] wr_data;
  logic       tx_empty, busy, sck, mosi;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int busy_len = 0;
  int last_len = 0;
  logic [7:0] exp_q[$];
  logic [7:0] sh;
  int nb = 0;
  logic prev_sck = 1'b0;

  spi_tx_master dut (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .cpol(cpol), .cpha(cpha),
    .wr_en(wr_en), .wr_data(wr_data), .tx_empty(tx_empty), .busy(busy),
    .sck(sck), .mosi(mosi)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ratio(input int d);
    return 2 << (2 * d);
  endfunction

  // monitor: rebuild bytes from sampling edges and compare with the queue
  always @(negedge clk) begin
    logic samp;
    samp = cpha ? (prev_sck != cpol && sck == cpol) : (prev_sck == cpol && sck != cpol);
    if (rst_n && busy && samp) begin
      sh = {sh[6:0], mosi};
      nb++;
      if (nb == 8) begin
        nb = 0;
        if (exp_q.size() == 0) begin
          chk(0, "R3 unexpected byte", int'(sh), -1);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(sh == e, "R3 R5 byte", int'(sh), int'(e));
        end
      end
    end
    if (!busy) nb = 0;
    prev_sck = sck;
    if (busy) busy_len++;
    else if (busy_len != 0) begin
      last_len = busy_len;
      busy_len = 0;
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (busy || !tx_empty);
    @(negedge clk);
  endtask

  task automatic put(input logic [7:0] b);
    while (!tx_empty) @(negedge clk);
    wr_en = 1'b1;
    wr_data = b;
    exp_q.push_back(b);
    @(negedge clk);
    wr_en = 1'b0;
    chk(tx_empty == 1'b0, "R6 empty clears", int'(tx_empty), 0);
  endtask

  task automatic single(input logic [7:0] b, input int skew);
    int t0, d, n;
    n = ratio(int'(div_sel));
    wait_idle();
    repeat (skew) @(negedge clk);
    put(b);
    t0 = cyc;
    while (!busy) @(negedge clk);
    d = cyc - t0;
    chk(d >= 1 && d <= n, "R8 start delay", d, n);
    chk(tx_empty == 1'b1, "R6 empty sets on load", int'(tx_empty), 1);
    wait_idle();
    chk(last_len == 8 * n, "R2 R10 busy length", last_len, 8 * n);
    chk(sck == cpol, "R4 idle level after byte", int'(sck), int'(cpol));
  endtask

  task automatic pair(input logic [7:0] a, input logic [7:0] b, input bit extra);
    int n;
    n = ratio(int'(div_sel));
    wait_idle();
    put(a);
    put(b);
    if (extra) begin
      wr_en = 1'b1;
      wr_data = 8'h3C;
      @(negedge clk);
      wr_en = 1'b0;
      chk(tx_empty == 1'b0, "R7 still full after ignored write", int'(tx_empty), 0);
    end
    wait_idle();
    chk(last_len == 16 * n, "R9 back to back length", last_len, 16 * n);
  endtask

  initial begin
    #1ms;
    bad++;
    total++;
    $display("FAIL watchdog R10 actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    div_sel = 2'd0; cpol = 1'b0; cpha = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    chk(tx_empty == 1'b1, "R1 reset empty", int'(tx_empty), 1);
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    @(negedge clk); @(negedge clk);
    chk(sck == cpol, "R1 reset sck", int'(sck), int'(cpol));

    for (int m = 0; m < 4; m++) begin
      cpol = m[1];
      cpha = m[0];
      repeat (3) @(negedge clk);
      chk(sck == cpol, "R4 idle level", int'(sck), int'(cpol));
      single(8'hA5 ^ 8'(m * 17), 0);
      pair(8'h81, 8'h7E ^ 8'(m), 1'b0);
    end

    cpol = 1'b1; cpha = 1'b0;
    for (int d = 0; d < 4; d++) begin
      div_sel = 2'(d);
      for (int k = 0; k < 3; k++) single(8'h5A + 8'(d * 3 + k), k * 2 + d);
    end

    div_sel = 2'd2; cpol = 1'b0; cpha = 1'b1;
    pair(8'hC3, 8'h1F, 1'b1);
    div_sel = 2'd1; cpha = 1'b0;
    pair(8'h00, 8'hFF, 1'b1);

    wait_idle();
    chk(exp_q.size() == 0, "R3 all bytes received", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule